// File: doc/BRIEF.md
# Card Clock Divider and Gate

This block derives the clock driven to a memory card from a fixed functional clock. A 3-bit code selects a power-of-two divide ratio from 1 to 128. With a 24 MHz functional clock, the slowest card clock is therefore 187.5 kHz. Software starts and stops the card clock with write-only strobe bits in a control word. A third strobe bit, written together with the start bit, asks the block to launch the command sequencer once the clock is running. That request is delivered as a single-cycle pulse.

The clock is switched on or off only at the boundary of a divided period, while the card clock is low, so no shortened high phase ever reaches the card. A running flag reports the real state of the gate. After a stop request, software polls this flag until it reads 0 before it touches the card bus. A new divide code that is written while the clock runs is held back until the current divided period has ended.

Top module: `card_clk_gen`

## Requirements
- R1: After reset the card clock is low, the running flag is 0, no launch pulse is driven and the active divide code is 0 (divide by 1).
- R2: A control write with bit 1 set and bit 0 clear starts a stopped clock at the write edge. The running flag reads 1 in the cycle that follows. The first divided period starts with its low half.
- R3: With code c ≥ 1 the card clock has a period of 2^c functional cycles: low for the first half and high for the second. With code 0 it follows the functional clock, except that the first high phase after a start comes one cycle after the write edge.
- R4: A code that is written (divide-code strobe) while the clock runs takes effect at the next period boundary, and the code in use holds until then. A code written while the clock is stopped is used by the next start.
- R5: A control write with bit 0 set stops the clock at the end of the current divided period, and the card clock then stays low. The running flag falls one cycle after the gating edge. In divide-by-1 mode, the last high phase follows the stop edge.
- R6: When bits 0 and 1 are both set in one write, stop takes priority, so a stopped clock stays stopped. A start write while the clock runs does not change the card clock pattern.
- R7: Control bit 2, written with bit 1 set and bit 0 clear, produces a single-cycle launch pulse in the cycle after the write, while the clock is running. Bit 2 written without bit 1 produces no pulse.
- R8: In divided modes the gate changes state only at an edge after which the card clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_we_i | input | 1 | Strobe that captures div_code_i |
| div_code_i | input | 3 | Divide code c, ratio 2^c |
| ctrl_we_i | input | 1 | Strobe for the control bits |
| ctrl_i | input | 3 | Bit 0 stop, bit 1 start, bit 2 launch command |
| card_clk_o | output | 1 | Gated, divided card clock |
| clk_running_o | output | 1 | 1 while the card clock gate is open |
| op_start_o | output | 1 | Single-cycle pulse that launches the command sequencer |

## Verification
The assertions check four rules on every edge. The card clock is low whenever the running flag is 0. The gate opens or closes only at a period boundary, with the card clock low. The active code moves only at a boundary. A launch pulse lasts one cycle and appears only while the clock runs. The bench scenarios are needed to show the exact waveform for each divide ratio, the cycle in which a deferred code or stop lands, and the one-cycle lag of the running flag. They also show that stop beats start and that a lone launch bit or a repeated start leaves the outputs untouched.

// File: rtl/card_clk_pkg.sv
`timescale 1ns/1ps
package card_clk_pkg;
  localparam int CTRL_W     = 3;
  localparam int CTRL_STOP  = 0;
  localparam int CTRL_START = 1;
  localparam int CTRL_OP    = 2;
endpackage

// File: rtl/cck_rst_sync.sv
`timescale 1ns/1ps
module cck_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/cck_divider.sv
`timescale 1ns/1ps
module cck_divider #(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              gate_next_i,
  output logic              wrap_o,
  output logic              phase_o,
  output logic              code_zero_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] code_pend_q, code_pend_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  mask_cur, mask_nxt, half_cur;

  function automatic logic [CNT_W-1:0] term_of(input logic [CODE_W-1:0] c);
    logic [CNT_W:0] t;
    t = ({{CNT_W{1'b0}}, 1'b1} << c) - 1'b1;
    return t[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] half_of(input logic [CODE_W-1:0] c);
    logic [CNT_W:0] t;
    t = ({{CNT_W{1'b0}}, 1'b1} << c) >> 1;
    return t[CNT_W-1:0];
  endfunction

  always_comb begin
    mask_cur    = term_of(code_q);
    half_cur    = half_of(code_q);
    wrap_o      = (cnt_q == mask_cur);
    code_pend_d = code_we_i ? code_i : code_pend_q;
    code_d      = wrap_o ? code_pend_d : code_q;
    mask_nxt    = term_of(code_d);
    if (!gate_next_i)  cnt_d = mask_nxt;
    else if (wrap_o)   cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_pend_q <= '0;
      code_q      <= '0;
      cnt_q       <= '0;
    end else begin
      code_pend_q <= code_pend_d;
      code_q      <= code_d;
      cnt_q       <= cnt_d;
    end
  end

  assign phase_o     = |(cnt_q & half_cur);
  assign code_zero_o = (code_q == '0);
  assign code_o      = code_q;
endmodule

// File: rtl/cck_request.sv
`timescale 1ns/1ps
module cck_request
  import card_clk_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              wrap_i,
  output logic              gate_o,
  output logic              gate_next_o,
  output logic              op_start_o
);
  logic start_pend_q, start_pend_d;
  logic stop_pend_q, stop_pend_d;
  logic gate_q, gate_d;
  logic op_pend_q, op_pend_d;
  logic op_fire_q, op_fire_d;
  logic start_req, stop_req, op_set, req_wr;

  always_comb begin
    req_wr    = ctrl_we_i && (ctrl_i[CTRL_STOP] || ctrl_i[CTRL_START]);
    stop_req  = req_wr ? ctrl_i[CTRL_STOP] : stop_pend_q;
    start_req = req_wr ? (ctrl_i[CTRL_START] && !ctrl_i[CTRL_STOP]) : start_pend_q;
    op_set    = ctrl_we_i && ctrl_i[CTRL_OP] && ctrl_i[CTRL_START] && !ctrl_i[CTRL_STOP];

    gate_d       = gate_q;
    start_pend_d = start_req;
    stop_pend_d  = stop_req;
    if (wrap_i) begin
      if (stop_req)       gate_d = 1'b0;
      else if (start_req) gate_d = 1'b1;
      start_pend_d = 1'b0;
      stop_pend_d  = 1'b0;
    end

    op_fire_d = op_pend_q && gate_q;
    op_pend_d = op_fire_d ? 1'b0 : (op_pend_q || op_set);
    if (wrap_i && stop_req) op_pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_pend_q <= 1'b0;
      stop_pend_q  <= 1'b0;
      gate_q       <= 1'b0;
      op_pend_q    <= 1'b0;
      op_fire_q    <= 1'b0;
    end else begin
      start_pend_q <= start_pend_d;
      stop_pend_q  <= stop_pend_d;
      gate_q       <= gate_d;
      op_pend_q    <= op_pend_d;
      op_fire_q    <= op_fire_d;
    end
  end

  assign gate_o      = gate_q;
  assign gate_next_o = gate_d;
  assign op_start_o  = op_fire_q;
endmodule

// File: rtl/cck_output.sv
`timescale 1ns/1ps
module cck_output (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic phase_i,
  input  logic code_zero_i,
  output logic card_clk_o,
  output logic running_o
);
  logic gate_lo_q;

  // second copy of the gate, updated while the functional clock is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_lo_q <= 1'b0;
    else         gate_lo_q <= gate_i;
  end

  always_comb begin
    if (code_zero_i) card_clk_o = clk_i & gate_lo_q;
    else             card_clk_o = gate_i & phase_i;
    running_o = gate_i | gate_lo_q;
  end
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen
  import card_clk_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              div_we_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              card_clk_o,
  output logic              clk_running_o,
  output logic              op_start_o
);
  logic              rst_sync_n;
  logic              wrap_w, phase_w, code_zero_w, gate_w, gate_next_w;
  logic [CODE_W-1:0] code_act_w;

  cck_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cck_divider #(.CODE_W(CODE_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .code_we_i   (div_we_i),
    .code_i      (div_code_i),
    .gate_next_i (gate_next_w),
    .wrap_o      (wrap_w),
    .phase_o     (phase_w),
    .code_zero_o (code_zero_w),
    .code_o      (code_act_w)
  );

  cck_request u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .ctrl_we_i   (ctrl_we_i),
    .ctrl_i      (ctrl_i),
    .wrap_i      (wrap_w),
    .gate_o      (gate_w),
    .gate_next_o (gate_next_w),
    .op_start_o  (op_start_o)
  );

  cck_output u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .gate_i      (gate_w),
    .phase_i     (phase_w),
    .code_zero_i (code_zero_w),
    .card_clk_o  (card_clk_o),
    .running_o   (clk_running_o)
  );
endmodule

// File: rtl/card_clk_gen_chk.sv
`timescale 1ns/1ps
module card_clk_gen_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              gate,
  input logic              wrap,
  input logic              code_zero,
  input logic [CODE_W-1:0] code_act,
  input logic              card_clk,
  input logic              running,
  input logic              op_start
);
  p_card_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    !running |-> !card_clk);

  p_gate_low_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!code_zero && $changed(gate)) |-> !card_clk);

  p_stop_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(gate) |-> $past(wrap));

  p_start_boundary_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(gate) |-> $past(wrap));

  p_code_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wrap |=> $stable(code_act));

  p_op_single_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_start |=> !op_start);

  p_op_running_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    op_start |-> running);
endmodule

bind card_clk_gen card_clk_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .gate      (gate_w),
  .wrap      (wrap_w),
  .code_zero (code_zero_w),
  .code_act  (code_act_w),
  .card_clk  (card_clk_o),
  .running   (clk_running_o),
  .op_start  (op_start_o)
);

// File: tb/card_clk_gen_tb_top.sv
`timescale 1ns/1ps
module card_clk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       div_we = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic       ctrl_we = 1'b0;
  logic [2:0] ctrl = 3'd0;
  logic       card_clk, running, op_start;

  int    nchk = 0, nfail = 0;
  int    t = 0, per = 1, base = 0, op_t = -1, stop_t = 0, nxt_base = 0, nxt_per = 1;
  int    code_model = 0;
  bit    fresh = 0, run_exp = 0, stop_v = 0, nxt_v = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  card_clk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .div_code_i(div_code),
    .ctrl_we_i(ctrl_we), .ctrl_i(ctrl), .card_clk_o(card_clk),
    .clk_running_o(running), .op_start_o(op_start)
  );

  function automatic bit exp_card(int j, int p, bit fr);
    if (p == 1) return !(fr && j == 0);
    return (j % p) >= (p / 2);
  endfunction

  function automatic int next_bound(int e, int b, int p);
    return b + ((e - b + p - 1) / p) * p;
  endfunction

  task automatic chk(string req, string what, bit act, bit expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, t, act, expv);
    end
  endtask

  task automatic tick();
    bit ec, er;
    @(posedge clk);
    #1;
    t++;
    ctrl_we = 1'b0;
    div_we  = 1'b0;
    if (nxt_v && t >= nxt_base) begin
      base = nxt_base; per = nxt_per; fresh = 0; nxt_v = 0;
    end
    if (run_exp && stop_v && t > stop_t) begin
      run_exp = 0; stop_v = 0;
    end
    if (!run_exp)                    begin ec = 0; er = 0; end
    else if (stop_v && t == stop_t)  begin ec = (per == 1); er = 1; end
    else                             begin ec = exp_card(t - base, per, fresh); er = 1; end
    chk(tag, "card_clk", card_clk, ec);
    chk(stop_v ? "R5" : tag, "running", running, er);
    chk("R7", "op_start", op_start, t == op_t);
  endtask

  task automatic do_code(int c);
    int e;
    e = t + 1;
    div_code = 3'(c); div_we = 1'b1;
    code_model = c;
    if (run_exp) begin
      nxt_v = 1; nxt_base = (per == 1) ? e : next_bound(e, base, per); nxt_per = 1 << c;
    end
    tick();
  endtask

  task automatic do_start(bit op);
    int e;
    e = t + 1;
    ctrl = {op, 1'b1, 1'b0}; ctrl_we = 1'b1;
    if (!run_exp) begin
      run_exp = 1; base = e; fresh = 1; per = 1 << code_model;
    end
    if (op) op_t = e + 1;
    tick();
  endtask

  task automatic do_stop(bit with_start);
    int e;
    e = t + 1;
    ctrl = {1'b0, with_start, 1'b1}; ctrl_we = 1'b1;
    if (run_exp) begin
      stop_v = 1; stop_t = (per == 1) ? e : next_bound(e, base, per);
    end
    tick();
  endtask

  task automatic do_op_only();
    ctrl = 3'b100; ctrl_we = 1'b1;
    tick();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(5.0 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int seed;
    int c, c2;
    seed = $urandom(32'h5eed);
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    tag = "R1";
    run(4);

    // R1 default code 0 used by first start, with launch from stopped (R7)
    tag = "R1";
    do_start(1'b1);
    tag = "R3";
    run(6);
    tag = "R5";
    do_stop(1'b0);
    while (run_exp) tick();
    run(2);

    // R6: stop and start together from stopped keeps the clock off
    tag = "R6";
    do_code(3);
    do_stop(1'b1);
    run(4);

    for (int it = 0; it < 12; it++) begin
      c = (it < 8) ? it : int'($urandom % 8);
      tag = "R4";
      do_code(c);
      run(1);
      tag = "R3";
      do_start(1'($urandom % 2));
      run(per + int'($urandom % (2 * per)) + 2);
      if (it % 3 == 1) begin
        tag = "R6";
        do_start(1'b0);
        run(3);
        tag = "R7";
        do_op_only();
        run(3);
        do_start(1'b1);
        run(3);
      end
      c2 = int'($urandom % 8);
      tag = "R4";
      do_code(c2);
      while (nxt_v) tick();
      run(2 * per + int'($urandom % 5));
      tag = (it % 2 == 1) ? "R6" : "R5";
      do_stop(1'(it % 2));
      while (run_exp) tick();
      run(3);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule